// File: doc/BRIEF.md
# Branch-Frequency Hang Detector

This block watches the stream of retired instructions and flags a likely endless loop. Each distinct branch address it sees gets its own execution counter in a small fully associative table. If any single branch comes to dominate execution, the hang flag rises and the address of that branch is captured. A branch dominates when its count passes a fixed absolute limit. It also dominates when its count, multiplied by a ratio, exceeds the number of instructions retired so far in the window. The ratio test only applies once enough instructions have retired that start-up noise is past.

Some branches are known to run hot in healthy code, and fault-free profiling identifies them. Their addresses are loaded into a small mask table through a write port. A masked branch never takes a table slot, is never counted and never raises the flag. Monitoring runs over fixed windows of retired instructions. When a window closes, the counters, the hang flag and the saturation flag all return to their reset state. The mask table is kept across windows. When every table slot is taken, an address not already in the table is dropped and a sticky saturation flag reports this.

Top module: `hang_watch`

## Requirements
- R1: After reset, hangFlag, hangPc and satFlag are all zero, the counter table is empty and every mask slot is invalid.
- R2: Each cycle with retValid high adds one to the window's retired count. A retirement with retBranch also high counts against its PC's table entry. A PC seen for the first time takes the lowest-numbered free entry with a count of one.
- R3: When a branch retirement brings that PC's count above ABS_LIMIT, hangFlag is high and hangPc holds that PC from the next clock edge on.
- R4: Let the window's retired count include the current instruction. If that count is at least MIN_TOTAL, a branch retirement whose new count times RATIO is strictly greater than the retired count raises hangFlag and loads hangPc, visible after the next edge.
- R5: A write with maskWe high stores maskPc into mask slot maskIdx and marks it valid. A branch whose PC matches a valid mask slot takes no table entry, gains no count and never raises hangFlag. It still adds to the retired count.
- R6: When all ENTRIES table slots are taken, a branch whose PC is not in the table is dropped and gains no count. satFlag then goes high and stays high until reset or the window closes.
- R7: The hang flag is sticky. Once set, later triggers by any PC leave hangFlag high and hangPc unchanged until reset or the window closes.
- R8: A retirement that arrives when the retired count equals WINDOW-1 closes the window. On the next edge the table is empty, the retired count is zero, and hangFlag, hangPc and satFlag are zero. That closing instruction is counted nowhere. Mask slots are kept.
- R9: While retValid is low, retBranch and retPc have no effect. A retirement with retBranch low changes no branch count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Active-low synchronous reset |
| retValid | input | 1 | One instruction retires this cycle |
| retBranch | input | 1 | The retiring instruction is a branch |
| retPc | input | PC_W | Address of the retiring branch |
| maskWe | input | 1 | Write strobe for the mask table |
| maskIdx | input | clog2(MASK_N) | Mask slot to write |
| maskPc | input | PC_W | Branch address to exclude |
| hangFlag | output | 1 | Sticky hang indication |
| hangPc | output | PC_W | Branch address that caused the hang |
| satFlag | output | 1 | Sticky table-full indication |

## Verification
The bench sweeps how many non-branch instructions come before a hot branch. This moves the ratio test across the point where the retired count reaches MIN_TOTAL and across the strict-versus-equal edge. A design that used greater-or-equal, or that left the current instruction out of the retired count, would flag one retirement early or one late. The bench fills the table around a masked PC and then offers a fifth address. If masked PCs took a slot, saturation would come early. If dropped PCs were counted, a false hang would appear. Running up to the window boundary checks that the closing retirement is counted nowhere and that the flags clear. A design off by one at the boundary, or one that also wiped the mask table, would show a hang on a masked branch or a stale count in the next window.

// File: rtl/hang_watch_pkg.sv
package hang_watch_pkg;

  // Strobes from the control module to the datapath for one retirement.
  typedef struct packed {
    logic clearAll;  // window closes: empty the table and drop the flags
    logic countRet;  // add one to the window retired count
    logic incHit;    // add one to the matching table entry
    logic allocNew;  // place the PC in the lowest free entry
    logic setSat;    // the table is full and the PC was dropped
    logic setHang;   // this retirement crosses a threshold
  } hwStrobe_t;

endpackage

// File: rtl/hang_watch_datapath.sv
module hang_watch_datapath
  import hang_watch_pkg::*;
#(
  parameter int PC_W    = 32,
  parameter int ENTRIES = 16,
  parameter int MASK_N  = 8,
  parameter int TOT_W   = 24,
  localparam int IdxW   = $clog2(ENTRIES),
  localparam int MidxW  = $clog2(MASK_N)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [PC_W-1:0]  retPc,
  input  logic             maskWe,
  input  logic [MidxW-1:0] maskIdx,
  input  logic [PC_W-1:0]  maskPc,
  input  hwStrobe_t        strb,
  output logic             hitAny,
  output logic             maskHit,
  output logic             freeAny,
  output logic [TOT_W-1:0] candCnt,
  output logic [TOT_W-1:0] totalNext,
  output logic [TOT_W-1:0] totalQ,
  output logic             hangFlag,
  output logic [PC_W-1:0]  hangPc,
  output logic             satFlag
);

  logic [ENTRIES-1:0] entValid;
  logic [PC_W-1:0]    entPc  [ENTRIES];
  logic [TOT_W-1:0]   entCnt [ENTRIES];
  logic [ENTRIES-1:0] hitVec;

  logic [MASK_N-1:0]  maskValid;
  logic [PC_W-1:0]    maskTab [MASK_N];
  logic [MASK_N-1:0]  maskVec;

  logic [TOT_W-1:0]   hitCnt;
  logic [IdxW-1:0]    freeIdx;

  // Address compare, one lane per table entry
  for (genvar i = 0; i < ENTRIES; i++) begin : gEntCmp
    assign hitVec[i] = entValid[i] && (entPc[i] == retPc);
  end

  // Address compare, one lane per mask slot
  for (genvar j = 0; j < MASK_N; j++) begin : gMaskCmp
    assign maskVec[j] = maskValid[j] && (maskTab[j] == retPc);
  end

  assign hitAny  = |hitVec;
  assign maskHit = |maskVec;
  assign freeAny = ~&entValid;

  // The hit vector has at most one bit set, so an OR merge picks the count
  always_comb begin
    hitCnt = '0;
    for (int i = 0; i < ENTRIES; i++) begin
      if (hitVec[i]) hitCnt = hitCnt | entCnt[i];
    end
  end

  // Lowest-numbered free entry
  always_comb begin
    freeIdx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (!entValid[i]) freeIdx = IdxW'(i);
    end
  end

  assign candCnt   = hitAny ? hitCnt + TOT_W'(1) : TOT_W'(1);
  assign totalNext = totalQ + TOT_W'(1);

  // Counter table, window count and flags
  always_ff @(posedge clk) begin
    if (!rstN) begin
      entValid <= '0;
      totalQ   <= '0;
      hangFlag <= 1'b0;
      hangPc   <= '0;
      satFlag  <= 1'b0;
      for (int i = 0; i < ENTRIES; i++) begin
        entPc[i]  <= '0;
        entCnt[i] <= '0;
      end
    end else if (strb.clearAll) begin
      entValid <= '0;
      totalQ   <= '0;
      hangFlag <= 1'b0;
      hangPc   <= '0;
      satFlag  <= 1'b0;
    end else begin
      if (strb.countRet) totalQ <= totalNext;
      if (strb.incHit) begin
        for (int i = 0; i < ENTRIES; i++) begin
          if (hitVec[i]) entCnt[i] <= candCnt;
        end
      end
      if (strb.allocNew) begin
        entValid[freeIdx] <= 1'b1;
        entPc[freeIdx]    <= retPc;
        entCnt[freeIdx]   <= TOT_W'(1);
      end
      if (strb.setSat) satFlag <= 1'b1;
      if (strb.setHang && !hangFlag) begin
        hangFlag <= 1'b1;
        hangPc   <= retPc;
      end
    end
  end

  // Mask table: only reset clears it, a window close does not
  always_ff @(posedge clk) begin
    if (!rstN) begin
      maskValid <= '0;
      for (int j = 0; j < MASK_N; j++) maskTab[j] <= '0;
    end else if (maskWe) begin
      maskValid[maskIdx] <= 1'b1;
      maskTab[maskIdx]   <= maskPc;
    end
  end

  // R2
  no_dup_entry_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(hitVec));

  // R2
  for (genvar i = 0; i < ENTRIES; i++) begin : gCntChk
    cnt_within_total_chk: assert property (@(posedge clk) disable iff (!rstN)
      entValid[i] |-> entCnt[i] <= totalQ);
  end

  // R5
  mask_no_track_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.incHit || strb.allocNew) |-> !maskHit);

  // R6
  sat_only_full_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setSat |=> satFlag && (&entValid));

  // R7
  hang_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (hangFlag && !strb.clearAll) |=> hangFlag && $stable(hangPc));

  // R8
  window_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.clearAll |=> (totalQ == '0) && !hangFlag && !satFlag && (entValid == '0));

endmodule

// File: rtl/hang_watch_control.sv
module hang_watch_control
  import hang_watch_pkg::*;
#(
  parameter int TOT_W     = 24,
  parameter int WINDOW    = 10_000_000,
  parameter int ABS_LIMIT = 100_000,
  parameter int RATIO     = 100,
  parameter int MIN_TOTAL = 100_000
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retValid,
  input  logic             retBranch,
  input  logic             hitAny,
  input  logic             maskHit,
  input  logic             freeAny,
  input  logic [TOT_W-1:0] candCnt,
  input  logic [TOT_W-1:0] totalNext,
  input  logic [TOT_W-1:0] totalQ,
  output hwStrobe_t        strb
);

  logic windowEnd;
  logic isBranch;
  logic tracked;
  logic absOver;
  logic relArmed;
  logic relOver;

  assign windowEnd = retValid && (totalQ == TOT_W'(WINDOW - 1));
  assign isBranch  = retValid && retBranch && !windowEnd;
  assign tracked   = isBranch && !maskHit;

  // Thresholds are compared in 64 bits, so the product cannot wrap
  assign absOver  = 64'(candCnt) > 64'(ABS_LIMIT);
  assign relArmed = 64'(totalNext) >= 64'(MIN_TOTAL);
  assign relOver  = relArmed && ((64'(candCnt) * 64'(RATIO)) > 64'(totalNext));

  always_comb begin
    strb          = '0;
    strb.clearAll = windowEnd;
    strb.countRet = retValid && !windowEnd;
    strb.incHit   = tracked && hitAny;
    strb.allocNew = tracked && !hitAny && freeAny;
    strb.setSat   = tracked && !hitAny && !freeAny;
    strb.setHang  = (strb.incHit || strb.allocNew) && (absOver || relOver);
  end

  // R2
  one_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.clearAll, strb.incHit, strb.allocNew, strb.setSat}));

  // R9
  hang_needs_branch_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.setHang |-> retValid && retBranch);

  // R9
  idle_no_action_chk: assert property (@(posedge clk) disable iff (!rstN)
    !retValid |-> (strb == '0));

endmodule

// File: rtl/hang_watch.sv
module hang_watch
  import hang_watch_pkg::*;
#(
  parameter int PC_W      = 32,
  parameter int ENTRIES   = 16,
  parameter int MASK_N    = 8,
  parameter int WINDOW    = 10_000_000,
  parameter int ABS_LIMIT = 100_000,
  parameter int RATIO     = 100,
  parameter int MIN_TOTAL = 100_000,
  localparam int MidxW    = $clog2(MASK_N),
  localparam int TotW     = $clog2(WINDOW + 1)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             retValid,
  input  logic             retBranch,
  input  logic [PC_W-1:0]  retPc,
  input  logic             maskWe,
  input  logic [MidxW-1:0] maskIdx,
  input  logic [PC_W-1:0]  maskPc,
  output logic             hangFlag,
  output logic [PC_W-1:0]  hangPc,
  output logic             satFlag
);

  hwStrobe_t        strb;
  logic             hitAny;
  logic             maskHit;
  logic             freeAny;
  logic [TotW-1:0]  candCnt;
  logic [TotW-1:0]  totalNext;
  logic [TotW-1:0]  totalQ;

  hang_watch_control #(
    .TOT_W(TotW), .WINDOW(WINDOW), .ABS_LIMIT(ABS_LIMIT),
    .RATIO(RATIO), .MIN_TOTAL(MIN_TOTAL)
  ) uCtrl (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retBranch(retBranch),
    .hitAny(hitAny), .maskHit(maskHit), .freeAny(freeAny),
    .candCnt(candCnt), .totalNext(totalNext), .totalQ(totalQ), .strb(strb)
  );

  hang_watch_datapath #(
    .PC_W(PC_W), .ENTRIES(ENTRIES), .MASK_N(MASK_N), .TOT_W(TotW)
  ) uData (
    .clk(clk), .rstN(rstN), .retPc(retPc), .maskWe(maskWe),
    .maskIdx(maskIdx), .maskPc(maskPc), .strb(strb),
    .hitAny(hitAny), .maskHit(maskHit), .freeAny(freeAny),
    .candCnt(candCnt), .totalNext(totalNext), .totalQ(totalQ),
    .hangFlag(hangFlag), .hangPc(hangPc), .satFlag(satFlag)
  );

endmodule

// File: tb/hang_watch_test.sv
module hang_watch_test;

  localparam int ClkPeriod = 10;
  localparam int PcW    = 16;
  localparam int Ent    = 4;
  localparam int MaskN  = 2;
  localparam int Win    = 120;
  localparam int AbsLim = 20;
  localparam int Ratio  = 4;
  localparam int MinTot = 40;

  logic           clk = 1'b0;
  logic           rstN = 1'b0;
  logic           retValid = 1'b0;
  logic           retBranch = 1'b0;
  logic [PcW-1:0] retPc = '0;
  logic           maskWe = 1'b0;
  logic [0:0]     maskIdx = '0;
  logic [PcW-1:0] maskPc = '0;
  logic           hangFlag;
  logic [PcW-1:0] hangPc;
  logic           satFlag;

  hang_watch #(
    .PC_W(PcW), .ENTRIES(Ent), .MASK_N(MaskN), .WINDOW(Win),
    .ABS_LIMIT(AbsLim), .RATIO(Ratio), .MIN_TOTAL(MinTot)
  ) uut (
    .clk(clk), .rstN(rstN), .retValid(retValid), .retBranch(retBranch),
    .retPc(retPc), .maskWe(maskWe), .maskIdx(maskIdx), .maskPc(maskPc),
    .hangFlag(hangFlag), .hangPc(hangPc), .satFlag(satFlag)
  );

  always #(ClkPeriod / 2) clk = ~clk;

  int    checks = 0;
  int    fails = 0;
  string curReq = "R1";
  int    cycles = 0;

  // Expected state, worked out from the requirements
  logic           mValid [Ent];
  logic [PcW-1:0] mPc    [Ent];
  int             mCnt   [Ent];
  logic           mMaskV [MaskN];
  logic [PcW-1:0] mMaskPc[MaskN];
  int             mTotal;
  logic           mHang;
  logic [PcW-1:0] mHangPc;
  logic           mSat;

  task automatic check(input string what, input int got, input int exp);
    checks++;
    if (got != exp) begin
      fails++;
      $display("FAIL %s %s got %0d expected %0d", curReq, what, got, exp);
    end
  endtask

  task automatic compareAll();
    check("hangFlag", int'(hangFlag), int'(mHang));
    check("hangPc", int'(hangPc), int'(mHangPc));
    check("satFlag", int'(satFlag), int'(mSat));
  endtask

  task automatic clearModel(input bit keepMask);
    for (int i = 0; i < Ent; i++) begin
      mValid[i] = 1'b0; mPc[i] = '0; mCnt[i] = 0;
    end
    if (!keepMask) begin
      for (int j = 0; j < MaskN; j++) begin
        mMaskV[j] = 1'b0; mMaskPc[j] = '0;
      end
    end
    mTotal = 0; mHang = 1'b0; mHangPc = '0; mSat = 1'b0;
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0; retValid = 1'b0; retBranch = 1'b0; maskWe = 1'b0;
    @(negedge clk);
    @(negedge clk);
    rstN = 1'b1;
    clearModel(1'b0);
  endtask

  // One cycle: check outputs from the last edge, drive, advance the model
  task automatic step(input bit v, input bit b, input logic [PcW-1:0] pc);
    int hit;
    int c;
    bit masked;
    @(negedge clk);
    compareAll();
    retValid = v; retBranch = b; retPc = pc; maskWe = 1'b0;
    if (!v) return;
    if (mTotal == Win - 1) begin
      clearModel(1'b1);
      return;
    end
    mTotal++;
    if (!b) return;
    masked = 1'b0;
    for (int j = 0; j < MaskN; j++) if (mMaskV[j] && mMaskPc[j] == pc) masked = 1'b1;
    if (masked) return;
    hit = -1;
    for (int i = 0; i < Ent; i++) if (mValid[i] && mPc[i] == pc) hit = i;
    if (hit < 0) begin
      for (int i = Ent - 1; i >= 0; i--) if (!mValid[i]) hit = i;
      if (hit < 0) begin
        mSat = 1'b1;
        return;
      end
      mValid[hit] = 1'b1; mPc[hit] = pc; mCnt[hit] = 0;
    end
    mCnt[hit]++;
    c = mCnt[hit];
    if (!mHang && (c > AbsLim || (mTotal >= MinTot && c * Ratio > mTotal))) begin
      mHang = 1'b1; mHangPc = pc;
    end
  endtask

  task automatic writeMask(input int idx, input logic [PcW-1:0] pc);
    @(negedge clk);
    compareAll();
    retValid = 1'b0; maskWe = 1'b1; maskIdx = 1'(idx); maskPc = pc;
    mMaskV[idx] = 1'b1; mMaskPc[idx] = pc;
  endtask

  task automatic finishRun();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  // Watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog got %0d cycles expected fewer", cycles);
      finishRun();
    end
  end

  initial begin
    clearModel(1'b0);
    // R1: reset state
    curReq = "R1";
    doReset();
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);

    // R9: branch pins toggling with retValid low, then non-branch retires
    curReq = "R9";
    for (int k = 0; k < 30; k++) step(1'b0, 1'b1, 16'h0A0);
    for (int k = 0; k < 10; k++) step(1'b1, 1'b0, 16'h0A0);

    // R3: absolute limit, total stays under MIN_TOTAL
    curReq = "R3";
    doReset();
    for (int k = 0; k < AbsLim + 3; k++) step(1'b1, 1'b1, 16'h0A0);

    // R7: a later trigger by another PC keeps the first PC
    curReq = "R7";
    for (int k = 0; k < AbsLim + 3; k++) step(1'b1, 1'b1, 16'h0B4);
    step(1'b0, 1'b0, '0);

    // R4: ratio test swept over the number of leading non-branch retires
    curReq = "R4";
    for (int pre = 28; pre <= 50; pre++) begin
      doReset();
      for (int k = 0; k < pre; k++) step(1'b1, 1'b0, '0);
      for (int k = 0; k < 18; k++) step(1'b1, 1'b1, 16'h100);
      step(1'b0, 1'b0, '0);
    end

    // R2: interleaved PCs fill entries in order and count separately
    curReq = "R2";
    doReset();
    for (int k = 0; k < 60; k++) step(1'b1, 1'b1, 16'(16'h200 + (k % 3) * 4));
    step(1'b0, 1'b0, '0);

    // R5: masked hot PC never tracked; table still has room for four others
    curReq = "R5";
    doReset();
    writeMask(0, 16'h300);
    writeMask(1, 16'h304);
    for (int k = 0; k < 50; k++) step(1'b1, 1'b1, (k % 2) ? 16'h304 : 16'h300);
    for (int k = 0; k < 4; k++) step(1'b1, 1'b1, 16'(16'h400 + k * 4));

    // R6: fifth address is dropped, raises saturation, never hangs
    curReq = "R6";
    for (int k = 0; k < 25; k++) step(1'b1, 1'b1, 16'h500);
    step(1'b0, 1'b0, '0);

    // R8: run to the window end; the closing branch is counted nowhere
    curReq = "R8";
    while (mTotal < Win - 1) step(1'b1, 1'b0, '0);
    step(1'b1, 1'b1, 16'h600);
    // Mask survives the close, entries free again, no hang from masked PC
    for (int k = 0; k < 30; k++) step(1'b1, 1'b1, 16'h300);
    for (int k = 0; k < AbsLim; k++) step(1'b1, 1'b1, 16'h600);
    step(1'b1, 1'b1, 16'h600);
    step(1'b0, 1'b0, '0);
    step(1'b0, 1'b0, '0);

    finishRun();
  end

endmodule